// File: doc/BRIEF.md
# Paired-Page Translation Buffer

This block is a small fully associative translation buffer for the mapped part of a virtual address space. Each entry holds one tag that covers a pair of adjacent virtual pages, and two frame descriptors: one for the even page and one for the odd page. Each descriptor has its own frame number, valid bit and dirty bit. The page size is chosen per entry by a mask field. The tag carries an address-space identifier and a global bit. A global entry matches under any identifier.

A request gives a virtual address, the current identifier, a write flag and a flag that suppresses faults. One cycle later the block returns one of three results. The first is a physical address with a writable indication. The second is a fault code, with a separate flag that tells a refill (no entry matched) apart from the other faults. The third, when faults are suppressed, is a plain translation failure. Software loads entries through an indexed write port. A write is visible to the next request. A write whose page mask is not one of the supported sizes is refused and flagged.

Top module: `paired_tlb`

## Requirements
- R1: A write with `wr_en` high and a legal mask replaces entry `wr_idx` on that clock edge. The new contents govern every request presented after that edge. Each request raised on an edge gives `rsp_valid` high on the following cycle.
- R2: The mask field `wr_mask` stands for virtual address bits [24:13]. It is legal only when it is 0, 0x003, 0x00F, 0x03F, 0x0FF, 0x3FF or 0xFFF, which give page shifts 12 to 24 in steps of 2. A write with any other mask leaves the entry unchanged and sets `wr_err` high on the following cycle. A legal write sets `wr_err` low.
- R3: The tag compare covers every virtual address bit from bit (pageshift+1) up to the top bit, so the top two region bits are included. Address bit [pageshift] selects the odd descriptor when it is 1 and the even descriptor when it is 0.
- R4: An entry matches when its tag matches and either its identifier equals `req_asid` or its global bit is set.
- R5: A match whose selected valid bit is clear gives `rsp_exc` = 2 for a read or 3 for a write, with `rsp_refill` low.
- R6: A valid match whose dirty bit is clear, on a write, gives `rsp_exc` = 1 (modify) with `rsp_refill` low.
- R7: A successful access gives `rsp_ok` high and `rsp_exc` = 0. `rsp_pa` is the frame number shifted left by 12, with its low pageshift bits cleared, ORed with the low pageshift bits of the address. `rsp_rw` equals the dirty bit.
- R8: When no entry matches, the response has `rsp_refill` high and `rsp_exc` = 2 for a read or 3 for a write.
- R9: With `req_noexc` high, a failed lookup gives `rsp_ok`, `rsp_exc` and `rsp_refill` all zero.
- R10: When several entries match, the lowest index supplies the result.
- R11: After reset no entry matches, so every lookup gives a refill, and `rsp_valid` and `wr_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Load an entry |
| wr_idx | input | IDX_W | Entry index to load |
| wr_mask | input | 12 | Page-size mask (address bits 24:13) |
| wr_vpn2 | input | VA_W-13 | Tag: virtual address bits above 12 |
| wr_asid | input | ASID_W | Tag identifier |
| wr_glob | input | 1 | Global bit: ignore the identifier |
| wr_pfn0 | input | PFN_W | Even page frame number |
| wr_v0 | input | 1 | Even page valid |
| wr_d0 | input | 1 | Even page dirty (writable) |
| wr_pfn1 | input | PFN_W | Odd page frame number |
| wr_v1 | input | 1 | Odd page valid |
| wr_d1 | input | 1 | Odd page dirty (writable) |
| wr_err | output | 1 | Previous write was refused for an illegal mask |
| req_valid | input | 1 | Lookup request |
| req_va | input | VA_W | Virtual address |
| req_asid | input | ASID_W | Current identifier |
| req_write | input | 1 | Access is a store |
| req_noexc | input | 1 | Suppress fault reporting |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_rw | output | 1 | Page is writable |
| rsp_exc | output | 2 | 0 none, 1 modify, 2 load fault, 3 store fault |
| rsp_refill | output | 1 | Fault came from a miss |
| rsp_pa | output | PFN_W+12 | Physical address |

## Verification
The bench goes after the per-entry page size. A design that took the odd/even select from a fixed bit, or that failed to clear the low frame bits of a large page, returns the wrong frame or a corrupted address on the 64 KiB and 16 MiB entries. It checks that a miss differs from an invalid match only in the refill flag, and that a clean page fails only on stores. A swapped priority or a dropped global bit shows up as the wrong frame or a spurious refill. It also checks that a refused write leaves the old mapping in place, and that suppression clears the fault code as well as the refill flag.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;

    localparam int MASK_W    = 12;
    localparam int PAGE_LSB  = 12;
    localparam int SPAN_W    = MASK_W + PAGE_LSB + 1;

    localparam logic [1:0] EXC_NONE  = 2'd0;
    localparam logic [1:0] EXC_MOD   = 2'd1;
    localparam logic [1:0] EXC_LOAD  = 2'd2;
    localparam logic [1:0] EXC_STORE = 2'd3;

    // Legal masks are a run of ones from bit 0 with an even length.
    function automatic logic mask_legal(input logic [MASK_W-1:0] m);
        logic [MASK_W:0] nxt;
        nxt = {1'b0, m} + 1'b1;
        return ((({1'b0, m}) & nxt) == '0) && !($countones(m) % 2);
    endfunction

    // Ones on the in-page offset bits [pageshift-1:0].
    function automatic logic [SPAN_W-1:0] offset_bits(input logic [MASK_W-1:0] m);
        logic [SPAN_W-1:0] full;
        full = {m, {(PAGE_LSB+1){1'b1}}};
        return full >> 1;
    endfunction

    // One-hot on address bit [pageshift].
    function automatic logic [SPAN_W-1:0] pair_bit(input logic [MASK_W-1:0] m);
        logic [SPAN_W-1:0] full;
        full = {m, {(PAGE_LSB+1){1'b1}}};
        return full ^ (full >> 1);
    endfunction

endpackage

// File: rtl/ptlb_match.sv
module ptlb_match #(
    parameter int VPN2_W = 27,
    parameter int ASID_W = 8
) (
    input  logic                        ent_used,
    input  logic [ptlb_pkg::MASK_W-1:0] ent_mask,
    input  logic [VPN2_W-1:0]           ent_vpn2,
    input  logic [ASID_W-1:0]           ent_asid,
    input  logic                        ent_glob,
    input  logic [VPN2_W-1:0]           va_vpn2,
    input  logic [ASID_W-1:0]           cur_asid,
    output logic                        hit
);
    logic [VPN2_W-1:0] care;
    logic              tag_eq;
    logic              id_ok;

    always_comb begin
        care   = ~VPN2_W'(ent_mask);
        tag_eq = ((va_vpn2 ^ ent_vpn2) & care) == '0;
        id_ok  = ent_glob || (ent_asid == cur_asid);
        hit    = ent_used && tag_eq && id_ok;
    end
endmodule

// File: rtl/ptlb_first.sv
module ptlb_first #(
    parameter int N     = 48,
    parameter int IDX_W = 6
) (
    input  logic [N-1:0]     hits,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |hits;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/ptlb_resolve.sv
module ptlb_resolve #(
    parameter int VA_W  = 40,
    parameter int PFN_W = 24,
    parameter int PA_W  = PFN_W + 12
) (
    input  logic                        hit,
    input  logic [ptlb_pkg::MASK_W-1:0] mask,
    input  logic [PFN_W-1:0]            pfn_even,
    input  logic                        v_even,
    input  logic                        d_even,
    input  logic [PFN_W-1:0]            pfn_odd,
    input  logic                        v_odd,
    input  logic                        d_odd,
    input  logic [VA_W-1:0]             va,
    input  logic                        is_write,
    input  logic                        no_exc,
    output logic                        ok,
    output logic                        rw,
    output logic [1:0]                  exc,
    output logic                        refill,
    output logic [PA_W-1:0]             pa
);
    import ptlb_pkg::*;

    logic [SPAN_W-1:0] offs;
    logic [SPAN_W-1:0] sel_bit;
    logic              odd;
    logic [PFN_W-1:0]  pfn;
    logic              v_sel;
    logic              d_sel;
    logic [PA_W-1:0]   offs_ext;
    logic [PA_W-1:0]   frame;
    logic [PA_W-1:0]   va_lo;
    logic [1:0]        acc_code;

    always_comb begin
        offs     = offset_bits(mask);
        sel_bit  = pair_bit(mask);
        odd      = |(va[SPAN_W-1:0] & sel_bit);
        pfn      = odd ? pfn_odd : pfn_even;
        v_sel    = odd ? v_odd : v_even;
        d_sel    = odd ? d_odd : d_even;
        offs_ext = PA_W'(offs);
        frame    = {pfn, {PAGE_LSB{1'b0}}};
        va_lo    = PA_W'(va[SPAN_W-1:0]);
        acc_code = is_write ? EXC_STORE : EXC_LOAD;

        ok     = 1'b0;
        rw     = 1'b0;
        exc    = EXC_NONE;
        refill = 1'b0;
        pa     = '0;

        if (!hit) begin
            exc    = acc_code;
            refill = 1'b1;
        end else if (!v_sel) begin
            exc = acc_code;
        end else if (is_write && !d_sel) begin
            exc = EXC_MOD;
        end else begin
            ok = 1'b1;
            rw = d_sel;
            pa = (frame & ~offs_ext) | (va_lo & offs_ext);
        end

        if (no_exc) begin
            exc    = EXC_NONE;
            refill = 1'b0;
        end
    end
endmodule

// File: rtl/paired_tlb.sv
module paired_tlb #(
    parameter int ENTRIES = 48,
    parameter int VA_W    = 40,
    parameter int ASID_W  = 8,
    parameter int PFN_W   = 24,
    parameter int IDX_W   = $clog2(ENTRIES),
    parameter int VPN2_W  = VA_W - 13,
    parameter int PA_W    = PFN_W + 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [ptlb_pkg::MASK_W-1:0] wr_mask,
    input  logic [VPN2_W-1:0]           wr_vpn2,
    input  logic [ASID_W-1:0]           wr_asid,
    input  logic                        wr_glob,
    input  logic [PFN_W-1:0]            wr_pfn0,
    input  logic                        wr_v0,
    input  logic                        wr_d0,
    input  logic [PFN_W-1:0]            wr_pfn1,
    input  logic                        wr_v1,
    input  logic                        wr_d1,
    output logic                        wr_err,
    input  logic                        req_valid,
    input  logic [VA_W-1:0]             req_va,
    input  logic [ASID_W-1:0]           req_asid,
    input  logic                        req_write,
    input  logic                        req_noexc,
    output logic                        rsp_valid,
    output logic                        rsp_ok,
    output logic                        rsp_rw,
    output logic [1:0]                  rsp_exc,
    output logic                        rsp_refill,
    output logic [PA_W-1:0]             rsp_pa
);
    import ptlb_pkg::*;

    typedef struct packed {
        logic              used;
        logic [MASK_W-1:0] mask;
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [PFN_W-1:0]  pfn0;
        logic              v0;
        logic              d0;
        logic [PFN_W-1:0]  pfn1;
        logic              v1;
        logic              d1;
    } ent_t;

    typedef struct packed {
        logic            valid;
        logic            ok;
        logic            rw;
        logic [1:0]      exc;
        logic            refill;
        logic [PA_W-1:0] pa;
        logic            wr_err;
    } rsp_t;

    ent_t ent_q [ENTRIES];
    ent_t ent_d [ENTRIES];
    rsp_t rsp_q;
    rsp_t rsp_d;

    logic [ENTRIES-1:0] hits;
    logic               any_hit;
    logic [IDX_W-1:0]   sel_idx;
    ent_t               sel;
    logic [VPN2_W-1:0]  va_vpn2;

    logic              r_ok;
    logic              r_rw;
    logic [1:0]        r_exc;
    logic              r_refill;
    logic [PA_W-1:0]   r_pa;

    assign va_vpn2 = req_va[VA_W-1:13];

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            ptlb_match #(
                .VPN2_W (VPN2_W),
                .ASID_W (ASID_W)
            ) u_match (
                .ent_used (ent_q[g].used),
                .ent_mask (ent_q[g].mask),
                .ent_vpn2 (ent_q[g].vpn2),
                .ent_asid (ent_q[g].asid),
                .ent_glob (ent_q[g].glob),
                .va_vpn2  (va_vpn2),
                .cur_asid (req_asid),
                .hit      (hits[g])
            );
        end
    endgenerate

    ptlb_first #(
        .N     (ENTRIES),
        .IDX_W (IDX_W)
    ) u_first (
        .hits (hits),
        .any  (any_hit),
        .idx  (sel_idx)
    );

    always_comb begin
        sel = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (sel_idx == IDX_W'(i)) sel = ent_q[i];
        end
    end

    ptlb_resolve #(
        .VA_W  (VA_W),
        .PFN_W (PFN_W),
        .PA_W  (PA_W)
    ) u_resolve (
        .hit      (any_hit),
        .mask     (sel.mask),
        .pfn_even (sel.pfn0),
        .v_even   (sel.v0),
        .d_even   (sel.d0),
        .pfn_odd  (sel.pfn1),
        .v_odd    (sel.v1),
        .d_odd    (sel.d1),
        .va       (req_va),
        .is_write (req_write),
        .no_exc   (req_noexc),
        .ok       (r_ok),
        .rw       (r_rw),
        .exc      (r_exc),
        .refill   (r_refill),
        .pa       (r_pa)
    );

    always_comb begin
        logic legal;
        legal = mask_legal(wr_mask);

        for (int i = 0; i < ENTRIES; i++) begin
            ent_d[i] = ent_q[i];
            if (wr_en && legal && (wr_idx == IDX_W'(i))) begin
                ent_d[i].used = 1'b1;
                ent_d[i].mask = wr_mask;
                ent_d[i].vpn2 = wr_vpn2;
                ent_d[i].asid = wr_asid;
                ent_d[i].glob = wr_glob;
                ent_d[i].pfn0 = wr_pfn0;
                ent_d[i].v0   = wr_v0;
                ent_d[i].d0   = wr_d0;
                ent_d[i].pfn1 = wr_pfn1;
                ent_d[i].v1   = wr_v1;
                ent_d[i].d1   = wr_d1;
            end
        end

        rsp_d.wr_err = wr_en && !legal;
        rsp_d.valid  = req_valid;
        if (req_valid) begin
            rsp_d.ok     = r_ok;
            rsp_d.rw     = r_rw;
            rsp_d.exc    = r_exc;
            rsp_d.refill = r_refill;
            rsp_d.pa     = r_pa;
        end else begin
            rsp_d.ok     = 1'b0;
            rsp_d.rw     = 1'b0;
            rsp_d.exc    = EXC_NONE;
            rsp_d.refill = 1'b0;
            rsp_d.pa     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
        end else begin
            rsp_q <= rsp_d;
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= ent_d[i];
        end
    end

    assign wr_err     = rsp_q.wr_err;
    assign rsp_valid  = rsp_q.valid;
    assign rsp_ok     = rsp_q.ok;
    assign rsp_rw     = rsp_q.rw;
    assign rsp_exc    = rsp_q.exc;
    assign rsp_refill = rsp_q.refill;
    assign rsp_pa     = rsp_q.pa;
endmodule

// File: rtl/paired_tlb_checker.sv
module paired_tlb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [11:0] wr_mask,
    input logic        wr_err,
    input logic        req_valid,
    input logic        req_write,
    input logic        req_noexc,
    input logic        rsp_valid,
    input logic        rsp_ok,
    input logic        rsp_rw,
    input logic [1:0]  rsp_exc,
    input logic        rsp_refill
);
    // R1: one response per request, one cycle later
    assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2: illegal mask on a write is flagged on the next cycle
    assert_bad_mask_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ptlb_pkg::mask_legal(wr_mask)) |=> wr_err);

    // R6: a modify fault only ever answers a store
    assert_mod_only_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> (rsp_exc != 2'd1));

    // R7: success carries no fault code
    assert_ok_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ok |-> (rsp_exc == 2'd0 && !rsp_refill));

    // R7: a store that succeeds landed on a writable page
    assert_store_writable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (!rsp_ok || rsp_rw));

    // R8: a refill always carries the load or store code
    assert_refill_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_refill |-> (rsp_exc[1] && rsp_valid));

    // R9: suppressed lookups report no fault
    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_noexc) |=> (rsp_exc == 2'd0 && !rsp_refill));
endmodule

bind paired_tlb paired_tlb_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_mask    (wr_mask),
    .wr_err     (wr_err),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_noexc  (req_noexc),
    .rsp_valid  (rsp_valid),
    .rsp_ok     (rsp_ok),
    .rsp_rw     (rsp_rw),
    .rsp_exc    (rsp_exc),
    .rsp_refill (rsp_refill)
);

// File: tb/paired_tlb_bench.sv
module paired_tlb_bench;
    localparam int ENTRIES = 48;
    localparam int VA_W    = 40;
    localparam int ASID_W  = 8;
    localparam int PFN_W   = 24;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int VPN2_W  = VA_W - 13;
    localparam int PA_W    = PFN_W + 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [11:0]       wr_mask = '0;
    logic [VPN2_W-1:0] wr_vpn2 = '0;
    logic [ASID_W-1:0] wr_asid = '0;
    logic              wr_glob = 1'b0;
    logic [PFN_W-1:0]  wr_pfn0 = '0;
    logic              wr_v0 = 1'b0;
    logic              wr_d0 = 1'b0;
    logic [PFN_W-1:0]  wr_pfn1 = '0;
    logic              wr_v1 = 1'b0;
    logic              wr_d1 = 1'b0;
    logic              wr_err;
    logic              req_valid = 1'b0;
    logic [VA_W-1:0]   req_va = '0;
    logic [ASID_W-1:0] req_asid = '0;
    logic              req_write = 1'b0;
    logic              req_noexc = 1'b0;
    logic              rsp_valid;
    logic              rsp_ok;
    logic              rsp_rw;
    logic [1:0]        rsp_exc;
    logic              rsp_refill;
    logic [PA_W-1:0]   rsp_pa;

    int  n_chk  = 0;
    int  n_err  = 0;
    bit  closed = 1'b0;

    always #2 clk = ~clk;

    paired_tlb #(
        .ENTRIES (ENTRIES),
        .VA_W    (VA_W),
        .ASID_W  (ASID_W),
        .PFN_W   (PFN_W)
    ) u_paired_tlb (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_mask    (wr_mask),
        .wr_vpn2    (wr_vpn2),
        .wr_asid    (wr_asid),
        .wr_glob    (wr_glob),
        .wr_pfn0    (wr_pfn0),
        .wr_v0      (wr_v0),
        .wr_d0      (wr_d0),
        .wr_pfn1    (wr_pfn1),
        .wr_v1      (wr_v1),
        .wr_d1      (wr_d1),
        .wr_err     (wr_err),
        .req_valid  (req_valid),
        .req_va     (req_va),
        .req_asid   (req_asid),
        .req_write  (req_write),
        .req_noexc  (req_noexc),
        .rsp_valid  (rsp_valid),
        .rsp_ok     (rsp_ok),
        .rsp_rw     (rsp_rw),
        .rsp_exc    (rsp_exc),
        .rsp_refill (rsp_refill),
        .rsp_pa     (rsp_pa)
    );

    typedef struct packed {
        logic [39:0] va;
        logic [7:0]  asid;
        logic        wr;
        logic        nx;
        logic        ok;
        logic        rw;
        logic [1:0]  exc;
        logic        refill;
        logic [35:0] pa;
        logic [3:0]  rq;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VEC [NVEC] = '{
        '{40'h0000400abc, 8'h11, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 36'h000123abc, 4'd7},  // R7 even page
        '{40'h0000401abc, 8'h11, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 36'h000456abc, 4'd3},  // R3 odd page, read-only
        '{40'h0000401abc, 8'h11, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 36'h0,          4'd6},  // R6 store to clean page
        '{40'h0000400abc, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, 36'h0,          4'd4},  // R4 wrong identifier
        '{40'h0001005678, 8'h33, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 36'h000805678, 4'd4},  // R4 global, 64K page
        '{40'h0001012345, 8'h33, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 36'h0,          4'd5},  // R5 invalid load
        '{40'h0001012345, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 36'h0,          4'd5},  // R5 invalid store
        '{40'h0002000010, 8'h11, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 36'h000333010, 4'd10}, // R10 lowest index
        '{40'h8000400abc, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, 36'h0,          4'd3},  // R3 region bit
        '{40'h0003000000, 8'h11, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 1'b1, 36'h0,          4'd8},  // R8 store miss
        '{40'h0003000000, 8'h11, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 36'h0,          4'd9},  // R9 quiet miss
        '{40'h0001012345, 8'h33, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 36'h0,          4'd9},  // R9 quiet invalid
        '{40'h0021001234, 8'h44, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 36'h00a001234, 4'd7},  // R7 16M page, odd
        '{40'h0001020000, 8'h33, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, 36'h0,          4'd3}   // R3 past the pair
    };

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic close_run();
        if (!closed) begin
            closed = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    task automatic load(input int idx, input logic [11:0] m, input logic [39:0] va_base,
                        input logic [7:0] asid, input logic g,
                        input logic [23:0] p0, input logic v0, input logic d0,
                        input logic [23:0] p1, input logic v1, input logic d1);
        wr_idx  = IDX_W'(idx);
        wr_mask = m;
        wr_vpn2 = va_base[39:13];
        wr_asid = asid;
        wr_glob = g;
        wr_pfn0 = p0; wr_v0 = v0; wr_d0 = d0;
        wr_pfn1 = p1; wr_v1 = v1; wr_d1 = d1;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic look(input logic [39:0] va, input logic [7:0] asid,
                        input logic wr, input logic nx);
        req_va    = va;
        req_asid  = asid;
        req_write = wr;
        req_noexc = nx;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        close_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        chk("R11 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk("R11 wr_err after reset", 64'(wr_err), 64'd0);
        look(40'h0, 8'h00, 1'b0, 1'b0);
        chk("R11 empty buffer refill", 64'(rsp_refill), 64'd1);
        chk("R11 empty buffer code", 64'(rsp_exc), 64'd2);

        load(5,  12'h000, 40'h0000400000, 8'h11, 1'b0, 24'h000123, 1'b1, 1'b1, 24'h000456, 1'b1, 1'b0);
        chk("R2 legal write no error", 64'(wr_err), 64'd0);
        load(7,  12'h00f, 40'h0001000000, 8'h00, 1'b1, 24'h000803, 1'b1, 1'b1, 24'h000a05, 1'b0, 1'b0);
        load(3,  12'h000, 40'h0002000000, 8'h11, 1'b0, 24'h000333, 1'b1, 1'b1, 24'h0, 1'b0, 1'b0);
        load(9,  12'h000, 40'h0002000000, 8'h11, 1'b0, 24'h000999, 1'b1, 1'b1, 24'h0, 1'b0, 1'b0);
        load(0,  12'hfff, 40'h0020000000, 8'h44, 1'b0, 24'h0, 1'b0, 1'b0, 24'h00abcd, 1'b1, 1'b1);

        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = VEC[i];
            look(v.va, v.asid, v.wr, v.nx);
            chk($sformatf("R1 vec%0d valid", i), 64'(rsp_valid), 64'd1);
            chk($sformatf("R%0d vec%0d ok", v.rq, i), 64'(rsp_ok), 64'(v.ok));
            chk($sformatf("R%0d vec%0d rw", v.rq, i), 64'(rsp_rw), 64'(v.rw));
            chk($sformatf("R%0d vec%0d exc", v.rq, i), 64'(rsp_exc), 64'(v.exc));
            chk($sformatf("R%0d vec%0d refill", v.rq, i), 64'(rsp_refill), 64'(v.refill));
            chk($sformatf("R%0d vec%0d pa", v.rq, i), 64'(rsp_pa), 64'(v.pa));
        end

        // R2: illegal masks are refused and leave the entry alone
        load(5, 12'h005, 40'h0000400000, 8'h11, 1'b0, 24'h000fff, 1'b1, 1'b1, 24'h0, 1'b0, 1'b0);
        chk("R2 gapped mask flagged", 64'(wr_err), 64'd1);
        load(5, 12'h001, 40'h0000400000, 8'h11, 1'b0, 24'h000eee, 1'b1, 1'b1, 24'h0, 1'b0, 1'b0);
        chk("R2 odd-length mask flagged", 64'(wr_err), 64'd1);
        look(40'h0000400abc, 8'h11, 1'b0, 1'b0);
        chk("R2 entry kept pa", 64'(rsp_pa), 64'h000123abc);

        // R1: overwrite, then look up at once
        load(5, 12'h000, 40'h0000400000, 8'h11, 1'b0, 24'h000777, 1'b1, 1'b1, 24'h0, 1'b0, 1'b0);
        chk("R1 overwrite accepted", 64'(wr_err), 64'd0);
        look(40'h0000400abc, 8'h11, 1'b0, 1'b0);
        chk("R1 new mapping pa", 64'(rsp_pa), 64'h000777abc);
        look(40'h0000401abc, 8'h11, 1'b0, 1'b0);
        chk("R1 odd now invalid", 64'(rsp_exc), 64'd2);
        chk("R5 invalid not refill", 64'(rsp_refill), 64'd0);

        // R10: drop the lower duplicate, higher index takes over
        load(3, 12'h000, 40'h0005000000, 8'h11, 1'b0, 24'h0, 1'b0, 1'b0, 24'h0, 1'b0, 1'b0);
        look(40'h0002000010, 8'h11, 1'b0, 1'b0);
        chk("R10 remaining match pa", 64'(rsp_pa), 64'h000999010);

        @(negedge clk);
        chk("R1 idle no response", 64'(rsp_valid), 64'd0);
        close_run();
    end
endmodule